// File: doc/BRIEF.md
# Power-Management Event Unit with Interrupt Request

This block gathers power-management events into a 16-bit event status register, masks them with a 16-bit event enable register and drives a level-sensitive system control interrupt. The interrupt is high while any enabled status bit from a fixed group of sources is set: timer, global lock, power button and real-time clock. Software reaches the registers through a 64-byte I/O window. The window can be placed anywhere in a 16-bit I/O space on a 64-byte boundary. Its base and its enable come from configuration values supplied on side inputs.

A free-running timer of parameterised width counts tick-enable pulses. It raises its status bit each time its top bit changes value, but only while its enable bit is set and its status bit is clear. Power-button, RTC and global-lock events arrive as one-cycle pulses on dedicated inputs. Software clears a status bit by writing a one to it.

Top module: `pm_event_unit`

## Requirements
- R1: After reset, status, enable and timer are all zero, the interrupt output is low and the I/O window is closed.
- R2: The window base is `cfg_base & 0xFFC0`. An access hits when `io_addr[15:6]` equals that base's bits 15..6, and `io_addr[5:0]` selects the register. Configuration inputs take effect one clock after they change.
- R3: The window decodes only while `cfg_ctl[0]` is 1. While it is closed, reads return zero and writes change nothing.
- R4: Register offsets are: status at 0x00, enable at 0x02 and timer at 0x08. Each is returned zero-extended in `io_rdata[31:0]`. Any other offset reads zero. The timer ignores writes. Read data is registered and appears after the clock edge on which `io_rd` is sampled.
- R5: Status bit positions, shared with the enable register, are: timer bit 0, global lock bit 5, power button bit 8 and RTC bit 10. A one-cycle pulse on `gbl_evt`, `pwrbtn_evt` or `rtc_evt` sets the matching status bit.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R7: `sci` is high when status AND enable has any of bits 0, 5, 8 or 10 set. It follows a change of status or enable one clock later.
- R8: The timer increments by one on every clock with `tmr_tick` high, holds otherwise and wraps to zero.
- R9: The timer status bit is set when the timer's top bit changes value, but only while enable bit 0 is 1 and status bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 32 | Configuration value holding the window base |
| cfg_ctl | input | 8 | Configuration byte; bit 0 opens the window |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 32 | Registered read data |
| tmr_tick | input | 1 | Timer increment enable |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| rtc_evt | input | 1 | RTC alarm event pulse |
| gbl_evt | input | 1 | Global-lock release event pulse |
| sci | output | 1 | Level system control interrupt |

## Verification
Each event source is pulsed in turn: first with its enable clear, which must leave the interrupt low while the status bit still latches, then with its enable set, which must raise the interrupt exactly one clock after the status change. A write that sets enable over an already pending status shows that the interrupt follows enable with the same one-clock delay. Clearing patterns (write zero, write one, and a write-one colliding with a set pulse) separate correct write-one-to-clear behaviour from plain overwrite or from clear-wins priority. The timer runs through a full top-bit toggle with its enable set and then again with it clear, and it is run to wrap-around, which separates armed from unarmed detection. Window tests move the base with junk in the low bits and close the window, which separates masked decode from a full-address compare.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

  localparam int REG_W  = 16;
  localparam int IO_AW  = 16;
  localparam int WIN_AW = 6;
  localparam int RD_W   = 32;

  localparam int B_TMR = 0;
  localparam int B_GBL = 5;
  localparam int B_PWR = 8;
  localparam int B_RTC = 10;

  localparam logic [WIN_AW-1:0] OFF_STS = 6'h00;
  localparam logic [WIN_AW-1:0] OFF_EN  = 6'h02;
  localparam logic [WIN_AW-1:0] OFF_TMR = 6'h08;

  localparam logic [REG_W-1:0] SCI_MASK =
    (REG_W'(1) << B_TMR) | (REG_W'(1) << B_GBL) |
    (REG_W'(1) << B_PWR) | (REG_W'(1) << B_RTC);

endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode
  import pm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       cfg_base,
  input  logic [7:0]        cfg_ctl,
  input  logic [IO_AW-1:0]  io_addr,
  output logic              hit,
  output logic [WIN_AW-1:0] off
);

  logic [IO_AW-1:WIN_AW] base_q;
  logic                  open_q;

  // configuration is registered so decode timing is fixed
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      open_q <= 1'b0;
    end else begin
      base_q <= cfg_base[IO_AW-1:WIN_AW];
      open_q <= cfg_ctl[0];
    end
  end

  assign hit = open_q && (io_addr[IO_AW-1:WIN_AW] == base_q);
  assign off = io_addr[WIN_AW-1:0];

  logic unused_cfg;
  assign unused_cfg = ^{cfg_base[31:IO_AW], cfg_base[WIN_AW-1:0], cfg_ctl[7:1]};

  // R3: a closed window never produces a hit on the next cycle
  a_r3_closed_no_hit: assert property (@(posedge clk) disable iff (rst)
    !cfg_ctl[0] |=> !hit);

endmodule

// File: rtl/pm_tick_timer.sv
module pm_tick_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [TMR_W-1:0] cnt,
  output logic             flip
);

  localparam int TOP = TMR_W - 1;

  logic [TMR_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt + TMR_W'(1);
  assign flip    = tick && (cnt_nxt[TOP] != cnt[TOP]);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt_nxt;
  end

  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt == $past(cnt) + TMR_W'(1));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] set_vec,
  input  logic             sts_wr,
  input  logic             en_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] sts,
  output logic [REG_W-1:0] en,
  output logic             sci
);

  genvar gi;
  generate
    for (gi = 0; gi < REG_W; gi++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)                       sts[gi] <= 1'b0;
        else if (set_vec[gi])          sts[gi] <= 1'b1;
        else if (sts_wr && wdata[gi])  sts[gi] <= 1'b0;
      end

      // R6: set has priority over a simultaneous clear
      a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_vec[gi] |=> sts[gi]);

      a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && wdata[gi] && !set_vec[gi]) |=> !sts[gi]);

      a_r6_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (!set_vec[gi] && !(sts_wr && wdata[gi])) |=> $stable(sts[gi]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        en <= '0;
    else if (en_wr) en <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) sci <= 1'b0;
    else     sci <= |(sts & en & SCI_MASK);
  end

  // R7: with no interrupt source enabled the line is low a clock later
  a_r7_masked_low: assert property (@(posedge clk) disable iff (rst)
    (~|(en & SCI_MASK)) |=> !sci);

endmodule

// File: rtl/pm_event_unit.sv
module pm_event_unit
  import pm_evt_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] cfg_base,
  input  logic [7:0]  cfg_ctl,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [15:0] io_wdata,
  output logic [31:0] io_rdata,
  input  logic        tmr_tick,
  input  logic        pwrbtn_evt,
  input  logic        rtc_evt,
  input  logic        gbl_evt,
  output logic        sci
);

  logic              hit;
  logic [WIN_AW-1:0] off;
  logic [TMR_W-1:0]  tmr_cnt;
  logic              tmr_flip;
  logic [REG_W-1:0]  sts, en, set_vec;
  logic              sts_wr, en_wr, tmr_set;
  logic [RD_W-1:0]   rd_mux;

  pm_win_decode u_dec (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_ctl(cfg_ctl),
    .io_addr(io_addr), .hit(hit), .off(off)
  );

  pm_tick_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .tick(tmr_tick), .cnt(tmr_cnt), .flip(tmr_flip)
  );

  // timer detection armed only while enabled and not already pending
  assign tmr_set = tmr_flip && en[B_TMR] && !sts[B_TMR];

  always_comb begin
    set_vec        = '0;
    set_vec[B_TMR] = tmr_set;
    set_vec[B_GBL] = gbl_evt;
    set_vec[B_PWR] = pwrbtn_evt;
    set_vec[B_RTC] = rtc_evt;
  end

  assign sts_wr = io_wr && hit && (off == OFF_STS);
  assign en_wr  = io_wr && hit && (off == OFF_EN);

  pm_evt_regs u_regs (
    .clk(clk), .rst(rst), .set_vec(set_vec), .sts_wr(sts_wr), .en_wr(en_wr),
    .wdata(io_wdata), .sts(sts), .en(en), .sci(sci)
  );

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (off)
        OFF_STS: rd_mux = RD_W'(sts);
        OFF_EN:  rd_mux = RD_W'(en);
        OFF_TMR: rd_mux = RD_W'(tmr_cnt);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= '0;
    else if (io_rd) io_rdata <= rd_mux;
  end

  // R3: reads outside an open window return zero
  a_r3_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !hit) |=> io_rdata == '0);

  // R9: disarmed timer never raises its clear status bit
  a_r9_disarmed: assert property (@(posedge clk) disable iff (rst)
    (!en[B_TMR] && !sts[B_TMR]) |=> !sts[B_TMR]);

  // R1: reset leaves the interrupt low
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> !sci);

endmodule

// File: tb/tb_pm_event_unit.sv
module tb_pm_event_unit;

  localparam int TW   = 10;
  localparam int HALF = 1 << (TW - 1);
  localparam logic [15:0] BASE = 16'h5A40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_base = '0;
  logic [7:0]  cfg_ctl = '0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        tmr_tick = 1'b0, pwrbtn_evt = 1'b0, rtc_evt = 1'b0, gbl_evt = 1'b0;
  logic        sci;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pm_event_unit #(.TMR_W(TW)) dut (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_ctl(cfg_ctl),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .tmr_tick(tmr_tick), .pwrbtn_evt(pwrbtn_evt),
    .rtc_evt(rtc_evt), .gbl_evt(gbl_evt), .sci(sci)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; d = io_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tmr_tick = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); tmr_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 sci after reset", 32'(sci), 0);
    rd(BASE, v); chk("R1 closed window read", v, 0);
    cfg_base = 32'h1234_5A7F; cfg_ctl = 8'h01;
    repeat (2) @(negedge clk);
    rd(BASE + 16'h00, v); chk("R1 status zero", v, 0);
    rd(BASE + 16'h02, v); chk("R1 enable zero", v, 0);
    rd(BASE + 16'h08, v); chk("R1 timer zero", v, 0);
  endtask

  task automatic t_window();
    logic [31:0] v;
    wr(BASE + 16'h02, 16'h0421);
    rd(BASE + 16'h02, v); chk("R2 enable via masked base", v, 32'h421);
    wr(16'h5A02, 16'hFFFF);
    rd(BASE + 16'h02, v); chk("R2 write below window ignored", v, 32'h421);
    rd(16'h5A82, v); chk("R2 read above window zero", v, 0);
    rd(BASE + 16'h04, v); chk("R4 unmapped offset zero", v, 0);
    cfg_ctl = 8'h00; repeat (2) @(negedge clk);
    rd(BASE + 16'h02, v); chk("R3 closed read zero", v, 0);
    wr(BASE + 16'h02, 16'h0000);
    cfg_ctl = 8'h01; repeat (2) @(negedge clk);
    rd(BASE + 16'h02, v); chk("R3 closed write ignored", v, 32'h421);
  endtask

  task automatic t_events();
    logic [31:0] v;
    wr(BASE + 16'h02, 16'h0000);
    @(negedge clk); pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0;
    @(negedge clk); chk("R7 power button not enabled keeps sci low", 32'(sci), 0);
    rd(BASE, v); chk("R5 power button at bit 8", v, 32'h100);
    wr(BASE + 16'h02, 16'h0100);
    chk("R7 sci one clock after enable", 32'(sci), 0);
    @(negedge clk); chk("R7 sci rises after enable", 32'(sci), 1);
    wr(BASE, 16'h0000);
    rd(BASE, v); chk("R6 write zero keeps status", v, 32'h100);
    wr(BASE, 16'h0100);
    @(negedge clk); chk("R7 sci falls after clear", 32'(sci), 0);
    rd(BASE, v); chk("R6 write one clears", v, 0);
    wr(BASE + 16'h02, 16'h0420);
    @(negedge clk); rtc_evt = 1'b1; @(negedge clk); rtc_evt = 1'b0;
    chk("R7 sci lags rtc status", 32'(sci), 0);
    @(negedge clk); chk("R7 sci from rtc", 32'(sci), 1);
    rd(BASE, v); chk("R5 rtc at bit 10", v, 32'h400);
    wr(BASE, 16'h0400);
    @(negedge clk); gbl_evt = 1'b1; @(negedge clk); gbl_evt = 1'b0;
    @(negedge clk); chk("R7 sci from global lock", 32'(sci), 1);
    rd(BASE, v); chk("R5 global lock at bit 5", v, 32'h20);
    // simultaneous set and write-one-clear
    @(negedge clk); io_addr = BASE; io_wdata = 16'h0120; io_wr = 1'b1; pwrbtn_evt = 1'b1;
    @(negedge clk); io_wr = 1'b0; pwrbtn_evt = 1'b0;
    rd(BASE, v); chk("R6 set beats clear", v, 32'h100);
    wr(BASE, 16'hFFFF);
    rd(BASE, v); chk("R6 all cleared", v, 0);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    wr(BASE + 16'h02, 16'h0001);
    ticks(5);
    rd(BASE + 16'h08, v); chk("R8 five ticks", v, 5);
    repeat (3) @(negedge clk);
    rd(BASE + 16'h08, v); chk("R8 holds without tick", v, 5);
    wr(BASE + 16'h08, 16'hFFFF);
    rd(BASE + 16'h08, v); chk("R4 timer ignores write", v, 5);
    ticks(HALF - 5);
    @(negedge clk);
    chk("R9 sci from timer toggle", 32'(sci), 1);
    rd(BASE, v); chk("R9 timer status set", v, 1);
    wr(BASE, 16'h0001);
    wr(BASE + 16'h02, 16'h0000);
    ticks(HALF);
    rd(BASE + 16'h08, v); chk("R8 wraps to zero", v, 0);
    rd(BASE, v); chk("R9 disarmed toggle ignored", v, 0);
    chk("R9 sci low when disarmed", 32'(sci), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_window();
    t_events();
    t_timer();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule